// File: doc/BRIEF.md
# Power-Domain Shutdown Sequencer

This block powers down up to three processor power domains, one after another, under hardware control. Each domain has a 7-bit power-control word, a cache-SRAM power-down request with a matching acknowledge, and two power-status inputs, one for the primary power switch and one for the secondary switch. A run first issues a single control-enable write. It then takes each selected domain through a fixed series of single-bit steps. The first group of steps isolates the domain and its SRAM. The sequencer then waits for the SRAM to confirm power-down. The second group removes reset, the clock and both power switches. The sequencer waits for both status inputs to read low before it moves on.

A `start_all_i` pulse walks domains 1, 2 and 3 in that order. A `start_one_i` pulse with `dom_idx_i` in 1..3 shuts down only that domain, and any other index does nothing. `done_o` marks the end of a run. Power-up sequencing and the register bus are handled elsewhere.

Top module: `pds_shutdown_seq`

## Requirements
- R1: While reset is active and after it is released, every domain word reads 7'h4D (bit 0 reset-release = 1, bit 1 isolation = 0, bit 2 primary on = 1, bit 3 secondary on = 1, bit 4 clock off = 0, bit 5 SRAM clock isolation = 0, bit 6 SRAM isolation released = 1). All SRAM requests, `busy_o`, `done_o` and `ctl_en_wr_o` read 0.
- R2: Each accepted start produces exactly one `ctl_en_wr_o` cycle carrying {16-bit key, 15'b0, 1'b1}, and it comes before any domain word changes.
- R3: The first phase changes one bit per cycle in this order: bit 1 set, bit 5 set, bit 6 cleared. The SRAM power-down request then rises, and the word does not change in that cycle.
- R4: While the acknowledge of the active domain is low, no second-phase change occurs. The domain word holds 7'h2F and its request stays high.
- R5: After the acknowledge, the second phase changes one bit per cycle in this order: bit 0 cleared, bit 4 set, bit 2 cleared, bit 3 cleared. The final word is 7'h32.
- R6: The sequencer does not go on to the next domain, and does not finish, until the domain's primary and secondary status bits both read low.
- R7: A full run handles internal domains 0, 1 and 2 (indices 1, 2, 3) strictly in order. Their status bits are at positions STAT_BASE+0..2 (10, 11, 12 by default).
- R8: `busy_o` is high for the whole run. `done_o` is high for exactly one cycle, after the last domain completes.
- R9: A start pulse that arrives while busy is ignored and causes no further enable write.
- R10: `start_one_i` with `dom_idx_i` = 1..3 shuts down only that domain. An index of 0 causes no enable write, no busy and no word change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_all_i | input | 1 | Begin a run over all domains in order |
| start_one_i | input | 1 | Begin a run over the domain given by dom_idx_i |
| dom_idx_i | input | 2 | Domain index, 1-based, for start_one_i |
| sram_ack_i | input | 3 | SRAM power-down acknowledge per domain |
| pwr_sta_i | input | 16 | Primary power status vector |
| pwr_sta2_i | input | 16 | Secondary power status vector |
| pwr_ctrl_o | output | 21 | Power-control words, domain d at [7d+6:7d] |
| sram_pdn_o | output | 3 | SRAM power-down request per domain |
| ctl_en_wr_o | output | 1 | Control-enable write strobe |
| ctl_en_word_o | output | 32 | Control-enable word |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
A wrong sequencer state would show on the domain words within one cycle. A skipped or repeated step changes the word to a value that is not next in the expected order, or changes two bits at once. A wrong domain pointer makes a word of a domain outside the run move, or makes the next domain start while the previous one's status is still high. A stall state that exits too early shows as a second-phase change before the acknowledge, or as `done_o` while a status input is still high.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int CTRL_W   = 7;
  localparam int B_RSTN   = 0;
  localparam int B_ISO    = 1;
  localparam int B_ON     = 2;
  localparam int B_ON2    = 3;
  localparam int B_CKOFF  = 4;
  localparam int B_SCKISO = 5;
  localparam int B_SISON  = 6;
  localparam logic [CTRL_W-1:0] CTRL_RST = 7'h4D;

  typedef enum logic [3:0] {
    ST_NONE, ST_ISO, ST_CKISO, ST_SISO, ST_PDN,
    ST_RST, ST_CLK, ST_ON, ST_ON2
  } step_e;

  typedef enum logic [3:0] {
    S_IDLE, S_KEY, S_ISO, S_CKISO, S_SISO, S_PDN, S_WACK,
    S_RST, S_CLK, S_ON, S_ON2, S_WSTA, S_DONE
  } seq_e;
endpackage

// File: rtl/pds_dom_ctrl.sv
module pds_dom_ctrl
  import pds_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              apply_i,
  input  step_e             step_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              pdn_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              pdn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      pdn_q  <= 1'b0;
    end else if (apply_i) begin
      case (step_i)
        ST_ISO:   ctrl_q[B_ISO]    <= 1'b1;
        ST_CKISO: ctrl_q[B_SCKISO] <= 1'b1;
        ST_SISO:  ctrl_q[B_SISON]  <= 1'b0;
        ST_PDN:   pdn_q            <= 1'b1;
        ST_RST:   ctrl_q[B_RSTN]   <= 1'b0;
        ST_CLK:   ctrl_q[B_CKOFF]  <= 1'b1;
        ST_ON:    ctrl_q[B_ON]     <= 1'b0;
        ST_ON2:   ctrl_q[B_ON2]    <= 1'b0;
        default:  ;
      endcase
    end
  end

  assign ctrl_o = ctrl_q;
  assign pdn_o  = pdn_q;

  // R3, R5: one bit changes per cycle at most
  a_r3_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ctrl_q ^ $past(ctrl_q)) <= 1);
  // R5: reset is removed only once the SRAM is isolated and requested down
  a_r5_rst_after_pdn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q[B_RSTN]) |-> (pdn_q && !ctrl_q[B_SISON] && ctrl_q[B_ISO]));
endmodule

// File: rtl/pds_sta_sel.sv
module pds_sta_sel #(
  parameter int NUM_DOM   = 3,
  parameter int STAT_W    = 16,
  parameter int STAT_BASE = 10,
  localparam int CUR_W    = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic [CUR_W-1:0]   cur_i,
  input  logic [NUM_DOM-1:0] sram_ack_i,
  input  logic [STAT_W-1:0]  pwr_sta_i,
  input  logic [STAT_W-1:0]  pwr_sta2_i,
  output logic               ack_o,
  output logic               sta_low_o
);
  logic [NUM_DOM-1:0] low_vec;
  logic               unused_sta;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_low
    assign low_vec[d] = !pwr_sta_i[STAT_BASE+d] && !pwr_sta2_i[STAT_BASE+d];
  end

  assign ack_o      = sram_ack_i[cur_i];
  assign sta_low_o  = low_vec[cur_i];
  assign unused_sta = ^{pwr_sta_i, pwr_sta2_i};
endmodule

// File: rtl/pds_seq_fsm.sv
module pds_seq_fsm
  import pds_pkg::*;
#(
  parameter int NUM_DOM = 3,
  localparam int IDX_W  = $clog2(NUM_DOM + 1),
  localparam int CUR_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_all_i,
  input  logic             start_one_i,
  input  logic [IDX_W-1:0] dom_idx_i,
  input  logic             ack_i,
  input  logic             sta_low_i,
  output logic [CUR_W-1:0] cur_o,
  output step_e            step_o,
  output logic             key_wr_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_e             state_q, state_d;
  logic [CUR_W-1:0] cur_q, cur_d, last_q, last_d;
  logic             one_ok;

  assign one_ok = start_one_i && (dom_idx_i != '0) &&
                  (int'(dom_idx_i) <= NUM_DOM);

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    last_d  = last_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_all_i) begin
          state_d = S_KEY;
          cur_d   = '0;
          last_d  = CUR_W'(NUM_DOM - 1);
        end else if (one_ok) begin
          state_d = S_KEY;
          cur_d   = CUR_W'(dom_idx_i - IDX_W'(1));
          last_d  = CUR_W'(dom_idx_i - IDX_W'(1));
        end
      end
      S_KEY:   state_d = S_ISO;
      S_ISO:   state_d = S_CKISO;
      S_CKISO: state_d = S_SISO;
      S_SISO:  state_d = S_PDN;
      S_PDN:   state_d = S_WACK;
      S_WACK:  if (ack_i) state_d = S_RST;
      S_RST:   state_d = S_CLK;
      S_CLK:   state_d = S_ON;
      S_ON:    state_d = S_ON2;
      S_ON2:   state_d = S_WSTA;
      S_WSTA: begin
        if (sta_low_i) begin
          if (cur_q == last_q) state_d = S_DONE;
          else begin
            state_d = S_ISO;
            cur_d   = cur_q + CUR_W'(1);
          end
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      last_q  <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      last_q  <= last_d;
    end
  end

  always_comb begin
    unique case (state_q)
      S_ISO:   step_o = ST_ISO;
      S_CKISO: step_o = ST_CKISO;
      S_SISO:  step_o = ST_SISO;
      S_PDN:   step_o = ST_PDN;
      S_RST:   step_o = ST_RST;
      S_CLK:   step_o = ST_CLK;
      S_ON:    step_o = ST_ON;
      S_ON2:   step_o = ST_ON2;
      default: step_o = ST_NONE;
    endcase
  end

  assign cur_o    = cur_q;
  assign key_wr_o = (state_q == S_KEY);
  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);

  a_r4_hold_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WACK && !ack_i) |=> (state_q == S_WACK));
  a_r6_hold_sta: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WSTA && !sta_low_i) |=> (state_q == S_WSTA && $stable(cur_q)));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r2_key_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_wr_o |=> (!key_wr_o && state_q == S_ISO));
  a_r9_busy_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (start_all_i || start_one_i)) |=> (state_q != S_KEY));
  a_r7_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != S_KEY && $changed(cur_q)) |-> (cur_q == $past(cur_q) + CUR_W'(1)));
endmodule

// File: rtl/pds_shutdown_seq.sv
module pds_shutdown_seq
  import pds_pkg::*;
#(
  parameter int          NUM_DOM   = 3,
  parameter int          STAT_W    = 16,
  parameter int          STAT_BASE = 10,
  parameter logic [15:0] PROJ_KEY  = 16'h0B16,
  localparam int         IDX_W     = $clog2(NUM_DOM + 1),
  localparam int         CUR_W     = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_all_i,
  input  logic                      start_one_i,
  input  logic [IDX_W-1:0]          dom_idx_i,
  input  logic [NUM_DOM-1:0]        sram_ack_i,
  input  logic [STAT_W-1:0]         pwr_sta_i,
  input  logic [STAT_W-1:0]         pwr_sta2_i,
  output logic [NUM_DOM*CTRL_W-1:0] pwr_ctrl_o,
  output logic [NUM_DOM-1:0]        sram_pdn_o,
  output logic                      ctl_en_wr_o,
  output logic [31:0]               ctl_en_word_o,
  output logic                      busy_o,
  output logic                      done_o
);
  logic [CUR_W-1:0] cur;
  step_e            step;
  logic             ack_cur, sta_low;

  pds_seq_fsm #(.NUM_DOM(NUM_DOM)) u_fsm (
    .clk_i, .rst_ni, .start_all_i, .start_one_i, .dom_idx_i,
    .ack_i(ack_cur), .sta_low_i(sta_low), .cur_o(cur), .step_o(step),
    .key_wr_o(ctl_en_wr_o), .busy_o, .done_o
  );

  pds_sta_sel #(.NUM_DOM(NUM_DOM), .STAT_W(STAT_W), .STAT_BASE(STAT_BASE)) u_sel (
    .cur_i(cur), .sram_ack_i, .pwr_sta_i, .pwr_sta2_i,
    .ack_o(ack_cur), .sta_low_o(sta_low)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    pds_dom_ctrl u_dom (
      .clk_i, .rst_ni,
      .apply_i(int'(cur) == d),
      .step_i (step),
      .ctrl_o (pwr_ctrl_o[d*CTRL_W +: CTRL_W]),
      .pdn_o  (sram_pdn_o[d])
    );
  end

  assign ctl_en_word_o = {PROJ_KEY, 15'b0, 1'b1};

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni || (!busy_o && !done_o)));
endmodule

// File: tb/pds_shutdown_seq_tb_top.sv
module pds_shutdown_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int ND    = 3;
  localparam int SB    = 10;
  localparam logic [31:0] KEY_WORD = {16'h0B16, 15'b0, 1'b1};
  // per-domain word after each change, in order (R3 then R5)
  localparam logic [6:0] STEP_TBL [7] = '{7'h4F, 7'h6F, 7'h2F, 7'h2E, 7'h3E, 7'h3A, 7'h32};

  logic        clk = 0, rst_n = 0;
  logic        start_all = 0, start_one = 0;
  logic [1:0]  dom_idx = 0;
  logic [2:0]  ack_en = 3'b111, hold1 = 0, hold2 = 0;
  logic [2:0]  sram_ack;
  logic [15:0] sta, sta2;
  logic [20:0] ctrl;
  logic [2:0]  pdn;
  logic        en_wr, busy, done;
  logic [31:0] en_word;
  logic        mon_clr = 1;

  int tb_chk = 0, tb_fail = 0, mon_chk = 0, mon_fail = 0;
  int idx [ND];
  logic [6:0] prev [ND];
  bit ack_seen [ND];
  int en_cnt = 0, done_cnt = 0;
  bit prev_done = 0;

  always #(CLK_P/2) clk = ~clk;

  assign sram_ack = pdn & ack_en;
  always_comb begin
    sta  = '0;
    sta2 = '0;
    for (int d = 0; d < ND; d++) begin
      sta[SB+d]  = ctrl[d*7+2] | hold1[d];
      sta2[SB+d] = ctrl[d*7+3] | hold2[d];
    end
  end

  pds_shutdown_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_all_i(start_all), .start_one_i(start_one),
    .dom_idx_i(dom_idx), .sram_ack_i(sram_ack), .pwr_sta_i(sta), .pwr_sta2_i(sta2),
    .pwr_ctrl_o(ctrl), .sram_pdn_o(pdn), .ctl_en_wr_o(en_wr), .ctl_en_word_o(en_word),
    .busy_o(busy), .done_o(done)
  );

  function automatic logic [6:0] wd(input int d);
    return ctrl[d*7 +: 7];
  endfunction

  // monitor: walks STEP_TBL per domain
  always @(negedge clk) begin
    if (mon_clr) begin
      for (int d = 0; d < ND; d++) begin
        idx[d] = 0; prev[d] = wd(d); ack_seen[d] = 0;
      end
      en_cnt = 0; done_cnt = 0; prev_done = 0;
    end else begin
      if (en_wr) begin
        en_cnt++;
        mon_chk++;
        if (en_word !== KEY_WORD) begin
          mon_fail++; $display("FAIL R2 enable word: got %h exp %h", en_word, KEY_WORD);
        end
      end
      if (done) begin
        done_cnt++;
        mon_chk++;
        if (prev_done || sta[SB+2] || sta2[SB+2]) begin
          mon_fail++; $display("FAIL R8 done: got prev=%0d exp prev=0", prev_done);
        end
      end
      prev_done = done;
      for (int d = 0; d < ND; d++) begin
        if (pdn[d] && ack_en[d]) ack_seen[d] = 1;
        if (wd(d) !== prev[d]) begin
          mon_chk++;
          if (idx[d] >= 7 || wd(d) !== STEP_TBL[idx[d]]) begin
            mon_fail++;
            $display("FAIL R3/R5 dom%0d step %0d: got %h exp %h", d, idx[d], wd(d),
                     (idx[d] < 7) ? STEP_TBL[idx[d]] : 7'h00);
          end
          if (en_cnt == 0) begin
            mon_fail++; $display("FAIL R2 dom%0d changed before enable write: got 0 exp 1", d);
          end
          if (idx[d] == 3 && !(pdn[d] && ack_seen[d])) begin
            mon_fail++; $display("FAIL R4 dom%0d phase 2 before ack: got %0d exp 1", d, ack_seen[d]);
          end
          if (idx[d] < 3 && pdn[d]) begin
            mon_fail++; $display("FAIL R3 dom%0d request early: got 1 exp 0", d);
          end
          if (idx[d] == 0) begin
            for (int j = 0; j < ND; j++) begin
              if (j < d && !(idx[j] == 0 || (idx[j] == 7 && !sta[SB+j] && !sta2[SB+j]))) begin
                mon_fail++; $display("FAIL R6/R7 dom%0d started with dom%0d at step %0d: exp 0 or 7 idle", d, j, idx[j]);
              end
              if (j > d && idx[j] != 0) begin
                mon_fail++; $display("FAIL R7 dom%0d started after dom%0d: got %0d exp 0", d, j, idx[j]);
              end
            end
          end
          idx[d]++;
          prev[d] = wd(d);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    tb_chk++;
    if (!ok) begin
      tb_fail++; $display("FAIL %s: got %h exp %h", tag, act, exp_v);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic do_reset();
    mon_clr = 1; rst_n = 0;
    ack_en = 3'b111; hold1 = 0; hold2 = 0;
    cyc(3); rst_n = 1; cyc(2); mon_clr = 0; cyc(1);
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 500; i++) begin
      cyc(1);
      if (done) begin seen = 1; break; end
    end
  endtask

  initial begin
    bit seen;
    do_reset();
    // R1 reset state
    for (int d = 0; d < ND; d++) chk(wd(d) == 7'h4D, "R1 reset word", 32'(wd(d)), 32'h4D);
    chk(pdn == 0 && !busy && !done && !en_wr, "R1 reset flags", {pdn, busy, done, en_wr}, 0);

    // full run with a late start that must be ignored (R7, R8, R9)
    start_all = 1; cyc(1); start_all = 0;
    chk(busy, "R8 busy after start", 32'(busy), 1);
    cyc(10);
    start_all = 1; start_one = 1; dom_idx = 2; cyc(1); start_all = 0; start_one = 0;
    wait_done(seen);
    chk(seen, "R8 done seen", 32'(seen), 1);
    cyc(1);
    chk(!busy && !done, "R8 idle after done", {busy, done}, 0);
    for (int d = 0; d < ND; d++) chk(wd(d) == 7'h32, "R5/R7 final word", 32'(wd(d)), 32'h32);
    chk(pdn == 3'b111, "R3 requests high", 32'(pdn), 32'h7);
    chk(en_cnt == 1, "R9 one enable write", en_cnt, 1);
    chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);

    // ack stall then status stall on domain 1 (R4, R6)
    do_reset();
    ack_en[0] = 0; hold2[0] = 1;
    start_all = 1; cyc(1); start_all = 0;
    cyc(40);
    chk(wd(0) == 7'h2F && pdn[0], "R4 hold at ack", 32'(wd(0)), 32'h2F);
    chk(wd(1) == 7'h4D && busy, "R4 next dom untouched", 32'(wd(1)), 32'h4D);
    ack_en[0] = 1;
    cyc(40);
    chk(wd(0) == 7'h32, "R6 dom1 down", 32'(wd(0)), 32'h32);
    chk(wd(1) == 7'h4D && busy && !done, "R6 wait on secondary status", 32'(wd(1)), 32'h4D);
    hold2[0] = 0; hold1[1] = 1;
    cyc(40);
    chk(wd(2) == 7'h4D && wd(1) == 7'h32, "R6 wait on primary status", 32'(wd(2)), 32'h4D);
    hold1[1] = 0;
    wait_done(seen);
    chk(seen && wd(2) == 7'h32, "R7 dom3 done", 32'(wd(2)), 32'h32);

    // single-domain start (R10)
    do_reset();
    start_one = 1; dom_idx = 0; cyc(1); start_one = 0;
    cyc(20);
    chk(!busy && en_cnt == 0, "R10 index 0 no action", en_cnt, 0);
    for (int d = 0; d < ND; d++) chk(wd(d) == 7'h4D, "R10 index 0 words", 32'(wd(d)), 32'h4D);
    start_one = 1; dom_idx = 3; cyc(1); start_one = 0;
    wait_done(seen);
    chk(seen && wd(2) == 7'h32, "R10 dom3 alone", 32'(wd(2)), 32'h32);
    chk(wd(0) == 7'h4D && wd(1) == 7'h4D && pdn[1:0] == 0, "R10 others untouched", {wd(0), wd(1)}, 32'h4D4D);
    chk(en_cnt == 1, "R10 one enable write", en_cnt, 1);
    cyc(2);

    $display("%0d/%0d checks passed", (tb_chk + mon_chk) - (tb_fail + mon_fail), tb_chk + mon_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL R8 watchdog: got no end of test exp finish");
    $display("%0d/%0d checks passed", (tb_chk + mon_chk) - (tb_fail + mon_fail), tb_chk + mon_chk + 1);
    $finish;
  end
endmodule